// File: doc/BRIEF.md
# Bus Read Cycle Sequencer

This block produces the control timing of one local-bus read transaction, as a processor bus unit would run it. After a start request it steps through the bus states T1, T2, T3, zero or more wait states TW, and T4. Each bus state is held for a fixed number of clock phases, set by a parameter. The block drives an active-low read strobe and a status bit that tells memory space from I/O space. It keeps adding wait states until the addressed device raises an active-high ready.

A hold-acknowledge input gives the bus to another master. While it is high, the strobe is released. This is modelled as an output-enable flag that drops low, with the strobe value parked high. The bus sequence keeps running while the strobe is released. The strobe stays high during the first phase of T2. This leaves time for the shared address/data lines to float before any device is told to drive them. A one-clock done pulse marks the end of the transfer. A new request can start directly from the last clock of T4, so back-to-back reads need no idle gap.

Top module: `bus_rd_seq`

## Requirements
- R1: While `rst_ni` is low, `state_o` is 0 (idle), `rd_n_o` is 1, `done_o` is 0 and `space_io_o` is 0. The reset is asynchronous, so it takes effect at once, including in the middle of a cycle.
- R2: `state_o` encodes the bus states as follows: idle=0, T1=1, T2=2, T3=3, TW=4, T4=5. Every state other than idle lasts `PH_PER_T` clocks (2 by default).
- R3: Once a request is accepted, the states run in the order T1, T2, T3, then zero or more TW, then T4.
- R4: When enabled, `rd_n_o` is low in every clock of T3 and TW. In T2 it is low from phase `FLOAT_PH` onward (the second clock by default). It is high in the first clock of T2 and in every other state.
- R5: `ready_i` is sampled only in the last clock of T3 and of each TW. If it is 0 there, a TW follows. If it is 1, T4 follows. Its value in any other clock has no effect.
- R6: `done_o` is high for exactly one clock, the last clock of T4.
- R7: `space_io_o` takes the value of `io_sel_i` when a request is accepted (1 = I/O space, 0 = memory space). It holds that value until the next acceptance.
- R8: While `hold_ack_i` is 1, `rd_oe_o` is 0 and `rd_n_o` reads 1, in the same clock and in any state. The state sequence is not affected.
- R9: `start_i` is accepted only in idle or in the last clock of T4. From the last clock of T4 the block goes straight to T1. At any other time `start_i` has no effect on the state or on `space_io_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request for a read cycle |
| io_sel_i | input | 1 | Address space of the request: 1 = I/O, 0 = memory |
| ready_i | input | 1 | Device ready, active high, already synchronous to `clk_i` |
| hold_ack_i | input | 1 | Bus granted to another master; releases the strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| rd_oe_o | output | 1 | Strobe output enable; 0 means high impedance |
| space_io_o | output | 1 | Status: 1 = I/O read, 0 = memory read |
| state_o | output | 3 | Current bus state (encoding in R2) |
| done_o | output | 1 | One-clock pulse at the end of the cycle |

## Verification
The properties assume that `ready_i` is already synchronous and holds a known level in every clock of T3 and TW. The block has no synchroniser, so a metastable or X value would be used as it is. One property states this assumption. The bench changes every input only at the falling clock edge, so each input has a known level at each rising edge. It also drives `ready_i` to a defined 0 or 1 throughout, including in the clocks where the value is ignored.

// File: rtl/bus_rd_pkg.sv
package bus_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bus_st_e;

  function automatic logic strobe_state(input bus_st_e st);
    return (st == ST_T3) || (st == ST_TW);
  endfunction
endpackage

// File: rtl/bus_rd_phase.sv
module bus_rd_phase #(
  parameter int PH_PER_T = 2,
  localparam int PH_W = (PH_PER_T > 1) ? $clog2(PH_PER_T) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  output logic [PH_W-1:0] ph_o,
  output logic            last_o
);
  logic [PH_W-1:0] ph_q;

  assign last_o = (ph_q == PH_W'(PH_PER_T - 1));
  assign ph_o   = ph_q;

  // phase restarts on every bus-state boundary, including TW repeats
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ph_q <= '0;
    else if (!run_i || last_o)  ph_q <= '0;
    else                        ph_q <= ph_q + 1'b1;
  end
endmodule

// File: rtl/bus_rd_fsm.sv
module bus_rd_fsm
  import bus_rd_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    ready_i,
  input  logic    last_i,
  output bus_st_e state_o,
  output logic    accept_o,
  output logic    done_o
);
  bus_st_e st_q, st_d;

  assign accept_o = start_i && ((st_q == ST_IDLE) || ((st_q == ST_T4) && last_i));
  assign done_o   = (st_q == ST_T4) && last_i;
  assign state_o  = st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept_o) st_d = ST_T1;
      ST_T1:   if (last_i)   st_d = ST_T2;
      ST_T2:   if (last_i)   st_d = ST_T3;
      ST_T3, ST_TW:
               if (last_i)   st_d = ready_i ? ST_T4 : ST_TW;
      ST_T4:   if (last_i)   st_d = accept_o ? ST_T1 : ST_IDLE;
      default:               st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/bus_rd_strobe.sv
module bus_rd_strobe
  import bus_rd_pkg::*;
#(
  parameter int PH_PER_T = 2,
  parameter int FLOAT_PH = 1,
  localparam int PH_W = (PH_PER_T > 1) ? $clog2(PH_PER_T) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  bus_st_e         state_i,
  input  logic [PH_W-1:0] ph_i,
  input  logic            hold_ack_i,
  input  logic            accept_i,
  input  logic            io_sel_i,
  output logic            rd_n_o,
  output logic            rd_oe_o,
  output logic            space_io_o
);
  logic t2_live;
  logic rd_act;
  logic io_q;

  // T2 strobe waits for the multiplexed bus to float
  assign t2_live = (state_i == ST_T2) && (32'(ph_i) >= FLOAT_PH);
  assign rd_act  = strobe_state(state_i) || t2_live;
  assign rd_oe_o = !hold_ack_i;
  assign rd_n_o  = !(rd_act && rd_oe_o);
  assign space_io_o = io_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       io_q <= 1'b0;
    else if (accept_i) io_q <= io_sel_i;
  end
endmodule

// File: rtl/bus_rd_seq.sv
module bus_rd_seq
  import bus_rd_pkg::*;
#(
  parameter int PH_PER_T = 2,
  parameter int FLOAT_PH = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       io_sel_i,
  input  logic       ready_i,
  input  logic       hold_ack_i,
  output logic       rd_n_o,
  output logic       rd_oe_o,
  output logic       space_io_o,
  output logic [2:0] state_o,
  output logic       done_o
);
  localparam int PH_W = (PH_PER_T > 1) ? $clog2(PH_PER_T) : 1;

  bus_st_e         state;
  logic [PH_W-1:0] ph;
  logic            last_ph;
  logic            accept;

  bus_rd_phase #(.PH_PER_T(PH_PER_T)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state != ST_IDLE),
    .ph_o   (ph),
    .last_o (last_ph)
  );

  bus_rd_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .ready_i  (ready_i),
    .last_i   (last_ph),
    .state_o  (state),
    .accept_o (accept),
    .done_o   (done_o)
  );

  bus_rd_strobe #(.PH_PER_T(PH_PER_T), .FLOAT_PH(FLOAT_PH)) u_strobe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_i    (state),
    .ph_i       (ph),
    .hold_ack_i (hold_ack_i),
    .accept_i   (accept),
    .io_sel_i   (io_sel_i),
    .rd_n_o     (rd_n_o),
    .rd_oe_o    (rd_oe_o),
    .space_io_o (space_io_o)
  );

  assign state_o = state;
endmodule

// File: rtl/bus_rd_seq_chk.sv
module bus_rd_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ready_i,
  input logic       hold_ack_i,
  input logic       rd_n_o,
  input logic       space_io_o,
  input logic [2:0] state_o,
  input logic       done_o
);
  // R4
  strobe_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> (state_o == 3'd2 || state_o == 3'd3 || state_o == 3'd4));

  // R4
  t2_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 && !$stable(state_o)) |-> rd_n_o);

  // R8
  hold_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_ack_i |-> rd_n_o);

  // R3
  wait_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && !$stable(state_o)) |-> $past(state_o) == 3'd3);

  // R3
  t4_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd5 && !$stable(state_o)) |-> ($past(state_o) == 3'd3 || $past(state_o) == 3'd4));

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  done_in_t4_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> state_o == 3'd5);

  // R7
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(space_io_o) |-> state_o == 3'd1);

  // R5 input assumption: ready known where it may be sampled
  ready_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 || state_o == 3'd4) |-> !$isunknown(ready_i));
endmodule

bind bus_rd_seq bus_rd_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ready_i    (ready_i),
  .hold_ack_i (hold_ack_i),
  .rd_n_o     (rd_n_o),
  .space_io_o (space_io_o),
  .state_o    (state_o),
  .done_o     (done_o)
);

// File: tb/tb_bus_rd_seq.sv
module tb_bus_rd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, io_sel_i = 1'b0, ready_i = 1'b0, hold_ack_i = 1'b0;
  logic rd_n_o, rd_oe_o, space_io_o, done_o;
  logic [2:0] state_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bus_rd_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .io_sel_i(io_sel_i),
    .ready_i(ready_i), .hold_ack_i(hold_ack_i), .rd_n_o(rd_n_o), .rd_oe_o(rd_oe_o),
    .space_io_o(space_io_o), .state_o(state_o), .done_o(done_o)
  );

  // {start, io_sel, ready, hold_ack} {rd_n, oe, space_io} {state} {done}
  // each line is one clock; default 2 clocks per bus state
  localparam logic [10:0] VEC [NVEC] = '{
    11'b1000_110_000_0, // memory request from idle
    11'b0000_110_001_0,
    11'b0000_110_001_0,
    11'b0000_110_010_0, // T2 first clock: strobe still high
    11'b0000_010_010_0,
    11'b0000_010_011_0,
    11'b0010_010_011_0, // ready high at end of T3
    11'b0000_110_101_0,
    11'b0000_110_101_1,
    11'b0000_110_000_0,
    11'b1100_110_000_0, // I/O request
    11'b0000_111_001_0,
    11'b0000_111_001_0,
    11'b0001_101_010_0, // hold ack: released
    11'b0001_101_010_0,
    11'b0000_011_011_0,
    11'b0000_011_011_0, // ready low -> TW
    11'b0010_011_100_0, // ready high mid-TW ignored
    11'b0000_011_100_0,
    11'b0000_011_100_0,
    11'b0010_011_100_0,
    11'b0000_111_101_0,
    11'b1000_111_101_1, // back-to-back memory request
    11'b0000_110_001_0,
    11'b1100_110_001_0, // start mid-cycle ignored
    11'b0000_110_010_0,
    11'b0000_010_010_0,
    11'b0010_010_011_0,
    11'b0010_010_011_0,
    11'b1000_110_101_0, // start in first clock of T4 ignored
    11'b0000_110_101_1,
    11'b0000_110_000_0
  };

  function automatic logic [6:0] outs();
    return {rd_n_o, rd_oe_o, space_io_o, state_o, done_o};
  endfunction

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (rd_n oe io state done)", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    #(CLK_PERIOD * 3 + 1);
    chk("R1 reset", outs(), 7'b110_000_0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1 chk("R1 after release", outs(), 7'b110_000_0);

    // vector table: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk_i);
      {start_i, io_sel_i, ready_i, hold_ack_i} = VEC[i][10:7];
      #1 chk($sformatf("vec %0d R2 R3 R4 R5 R6 R7 R8 R9", i), outs(), VEC[i][6:0]);
    end

    // R8: hold ack while idle
    @(negedge clk_i);
    {start_i, io_sel_i, ready_i, hold_ack_i} = 4'b0001;
    #1 chk("R8 idle hold", outs(), 7'b100_000_0);

    // R10-style async reset mid-cycle, checked against R1
    @(negedge clk_i);
    {start_i, io_sel_i, ready_i, hold_ack_i} = 4'b1100;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      start_i = 1'b0;
    end
    #1 chk("R4 T3 before reset", outs(), 7'b011_011_0);
    rst_ni = 1'b0;
    #1 chk("R1 async reset mid-cycle", outs(), 7'b110_000_0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1 chk("R1 stays idle after reset", outs(), 7'b110_000_0);

    finish_run();
  end
endmodule